// File: doc/BRIEF.md
# Reset Source Sequencer with Start-up Delay

This block decides when the core of a small microcontroller leaves reset and records why it was reset. Four things can start a reset: a power-on detect pulse, an active-low external reset pin, a watchdog time-out pulse, and the pin or the watchdog arriving while the core sits in its low-power HALT state. The block drives a registered core reset. While that reset is high it also drives the core's initial state: a zero program-counter vector, ports forced to input, the stack pointer set to its top, and a low carrier output.

Two status flags are left behind for firmware to read after start. The time-out flag says that a watchdog expiry caused the reset. The power-down flag says that the reset was a wake from HALT or happened during HALT. Some causes leave the flags as they were.

After power-up and after any wake from HALT, a start-up counter holds the core in reset for a fixed number of clock cycles so that the oscillator can settle. A plain pin reset during normal running skips this delay. When the core leaves reset, a one-cycle strobe marks the moment.

Top module: `rst_seq_ctrl`

## Requirements
- R1: `por_i` and the inverted `pin_rst_ni` each pass through a `SYNC_STG`-stage synchroniser. The synchroniser asserts asynchronously and releases only after `SYNC_STG` clock edges. `core_rst_o` is high in the cycle after any edge that sees an active source.
- R2: Power-on reset clears both `to_flag_o` and `pdf_flag_o` to 0 and applies the start-up delay. `core_rst_o` first reads 0 after the `SYNC_STG+STARTUP_CYC`-th edge following the release of `por_i`.
- R3: A pin reset with `halt_i` low leaves both flags unchanged and applies no delay. `core_rst_o` first reads 0 after the `SYNC_STG+1`-th edge following the release of the pin.
- R4: A pin reset with `halt_i` high sets `to_flag_o`=0 and `pdf_flag_o`=1 and applies the delay. `core_rst_o` first reads 0 after the `SYNC_STG+STARTUP_CYC`-th edge following the release of the pin.
- R5: A one-cycle `wdt_tmo_i` pulse with `halt_i` low sets `to_flag_o`=1 and leaves `pdf_flag_o` unchanged. `core_rst_o` is high for exactly the one cycle after the edge that samples the pulse.
- R6: A `wdt_tmo_i` pulse with `halt_i` high sets both flags to 1. `core_rst_o` first reads 0 after the `STARTUP_CYC`-th edge counted from the sampling edge.
- R7: `wake_stb_o` is high for exactly one cycle: the first cycle in which `core_rst_o` reads 0 after being 1.
- R8: When several causes are active in the same cycle, power-on wins over the pin, and the pin wins over the watchdog. The flags follow the winning cause only.
- R9: A new reset that arrives while the start-up count runs restarts the full count. The delay stays required even if the new cause alone would not need it.
- R10: While `core_rst_o` is high, `wdt_tmo_i` has no effect and `halt_i` is not taken into account: flags and release timing stay as the running sequence set them.
- R11: While `core_rst_o` is high, `io_input_o` and `sp_init_o` are 1 and `carrier_o` is 0. Otherwise `carrier_o` follows `carrier_req_i` one cycle later. `pc_vec_o` is always all zeros.
- R12: The start-up counter is `$clog2(STARTUP_CYC)` bits wide and never exceeds `STARTUP_CYC-1`. The default of 1024 cycles gives a 10-bit counter.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System oscillator clock |
| por_i | input | 1 | Power-on detect, active high, asynchronous |
| pin_rst_ni | input | 1 | External reset pin, active low, asynchronous |
| wdt_tmo_i | input | 1 | Watchdog time-out pulse, synchronous |
| halt_i | input | 1 | Core is in HALT |
| carrier_req_i | input | 1 | Carrier value requested by the core |
| core_rst_o | output | 1 | Registered core reset, active high |
| wake_stb_o | output | 1 | One-cycle strobe when reset ends |
| to_flag_o | output | 1 | Time-out status flag |
| pdf_flag_o | output | 1 | Power-down status flag |
| pc_vec_o | output | PC_W | Program counter reset vector |
| io_input_o | output | 1 | Force ports to input mode |
| sp_init_o | output | 1 | Set stack pointer to top of stack |
| carrier_o | output | 1 | Carrier output, low during reset |

## Verification
The bench builds the block with `STARTUP_CYC`=16, `SYNC_STG`=2 and `PC_W`=12. The short count keeps each delayed release to 18 edges, so every cause can be exercised back to back, in both normal and HALT state, within a short run. With the same setting, a restart in the middle of a count and a watchdog pulse during a count land at known edges. The release edge is measured exactly for each cause, which separates a delayed release from an undelayed one by more than the synchroniser latency.

// File: rtl/rsq_pkg.sv
package rsq_pkg;
  typedef enum logic [1:0] {
    SRC_NONE = 2'd0,
    SRC_POR  = 2'd1,
    SRC_PIN  = 2'd2,
    SRC_WDT  = 2'd3
  } rst_src_e;
endpackage

// File: rtl/rsq_sync.sv
module rsq_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic arst_i,
  output logic sync_o
);
  logic [STAGES-1:0] sh_q;

  // Asynchronous set, release shifted in over STAGES edges (R1)
  always_ff @(posedge clk_i or posedge arst_i) begin
    if (arst_i) sh_q <= '1;
    else        sh_q <= {sh_q[STAGES-2:0], 1'b0};
  end

  assign sync_o = sh_q[STAGES-1];
endmodule

// File: rtl/rsq_cause.sv
module rsq_cause
  import rsq_pkg::*;
(
  input  logic clk_i,
  input  logic por_s_i,
  input  logic pin_s_i,
  input  logic wdt_i,
  input  logic halt_i,
  input  logic core_rst_i,
  output logic src_act_o,
  output logic dly_set_o,
  output logic to_o,
  output logic pdf_o
);
  rst_src_e src;
  logic     halt_q_v;
  logic     wdt_v;
  logic     to_q, pdf_q;

  // HALT and watchdog only count while the core runs (R10)
  assign halt_q_v = halt_i & ~core_rst_i;
  assign wdt_v    = wdt_i  & ~core_rst_i;

  // Priority: power-on, then pin, then watchdog (R8)
  always_comb begin
    if (por_s_i)      src = SRC_POR;
    else if (pin_s_i) src = SRC_PIN;
    else if (wdt_v)   src = SRC_WDT;
    else              src = SRC_NONE;
  end

  assign src_act_o = (src != SRC_NONE);
  assign dly_set_o = (src == SRC_POR) |
                     (((src == SRC_PIN) | (src == SRC_WDT)) & halt_q_v);

  always_ff @(posedge clk_i) begin
    if (por_s_i) begin
      to_q  <= 1'b0;
      pdf_q <= 1'b0;
    end else begin
      unique case (src)
        SRC_PIN: if (halt_q_v) begin
          to_q  <= 1'b0;
          pdf_q <= 1'b1;
        end
        SRC_WDT: begin
          to_q <= 1'b1;
          if (halt_q_v) pdf_q <= 1'b1;
        end
        default: ;
      endcase
    end
  end

  assign to_o  = to_q;
  assign pdf_o = pdf_q;

  a_r3_pin_keeps_flags: assert property (@(posedge clk_i) disable iff (por_s_i)
    (src == SRC_PIN && !halt_q_v) |=> $stable({to_q, pdf_q}));
  a_r4_pin_halt_flags: assert property (@(posedge clk_i) disable iff (por_s_i)
    (src == SRC_PIN && halt_q_v) |=> (!to_q && pdf_q));
  a_r5_wdt_sets_to: assert property (@(posedge clk_i) disable iff (por_s_i)
    (src == SRC_WDT) |=> to_q);
  a_r6_wdt_halt_sets_pdf: assert property (@(posedge clk_i) disable iff (por_s_i)
    (src == SRC_WDT && halt_q_v) |=> pdf_q);
endmodule

// File: rtl/rsq_sst.sv
module rsq_sst #(
  parameter int unsigned CYC = 1024,
  localparam int unsigned CW = $clog2(CYC)
) (
  input  logic clk_i,
  input  logic por_i,
  input  logic clr_i,
  input  logic run_i,
  output logic done_o
);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;

  assign done_o = run_i && (cnt_q == LAST);

  always_ff @(posedge clk_i) begin
    if (clr_i)      cnt_q <= '0;
    else if (run_i) cnt_q <= done_o ? '0 : cnt_q + 1'b1;
  end

  a_r12_cnt_bound: assert property (@(posedge clk_i) disable iff (por_i)
    cnt_q <= LAST);
endmodule

// File: rtl/rst_seq_ctrl.sv
module rst_seq_ctrl #(
  parameter int unsigned STARTUP_CYC = 1024,
  parameter int unsigned SYNC_STG    = 2,
  parameter int unsigned PC_W        = 12
) (
  input  logic            clk_i,
  input  logic            por_i,
  input  logic            pin_rst_ni,
  input  logic            wdt_tmo_i,
  input  logic            halt_i,
  input  logic            carrier_req_i,
  output logic            core_rst_o,
  output logic            wake_stb_o,
  output logic            to_flag_o,
  output logic            pdf_flag_o,
  output logic [PC_W-1:0] pc_vec_o,
  output logic            io_input_o,
  output logic            sp_init_o,
  output logic            carrier_o
);
  localparam logic [PC_W-1:0] RST_VEC = '0;

  logic por_s, pin_s, pin_a;
  logic src_act, dly_set, sst_done, sst_run;
  logic core_rst_q, dly_need_q, wake_q, carrier_q;
  logic rst_nxt;

  assign pin_a = ~pin_rst_ni;

  rsq_sync #(.STAGES(SYNC_STG)) u_por_sync (
    .clk_i (clk_i), .arst_i(por_i), .sync_o(por_s));
  rsq_sync #(.STAGES(SYNC_STG)) u_pin_sync (
    .clk_i (clk_i), .arst_i(pin_a), .sync_o(pin_s));

  rsq_cause u_cause (
    .clk_i     (clk_i),
    .por_s_i   (por_s),
    .pin_s_i   (pin_s),
    .wdt_i     (wdt_tmo_i),
    .halt_i    (halt_i),
    .core_rst_i(core_rst_q),
    .src_act_o (src_act),
    .dly_set_o (dly_set),
    .to_o      (to_flag_o),
    .pdf_o     (pdf_flag_o)
  );

  // Count only while held in a delayed reset with no source active (R9)
  assign sst_run = core_rst_q & dly_need_q & ~src_act;

  rsq_sst #(.CYC(STARTUP_CYC)) u_sst (
    .clk_i (clk_i),
    .por_i (por_s),
    .clr_i (src_act),
    .run_i (sst_run),
    .done_o(sst_done)
  );

  assign rst_nxt = src_act | (core_rst_q & dly_need_q & ~sst_done);

  always_ff @(posedge clk_i) begin
    if (por_s) begin
      core_rst_q <= 1'b1;
      dly_need_q <= 1'b1;
      wake_q     <= 1'b0;
      carrier_q  <= 1'b0;
    end else begin
      core_rst_q <= rst_nxt;
      wake_q     <= core_rst_q & ~rst_nxt;
      carrier_q  <= carrier_req_i & ~rst_nxt;
      if (src_act)                   dly_need_q <= dly_need_q | dly_set;
      else if (core_rst_q & ~rst_nxt) dly_need_q <= 1'b0;
    end
  end

  assign core_rst_o = core_rst_q;
  assign wake_stb_o = wake_q;
  assign carrier_o  = carrier_q;
  assign io_input_o = core_rst_q;
  assign sp_init_o  = core_rst_q;
  assign pc_vec_o   = RST_VEC;

  a_r1_source_holds_reset: assert property (@(posedge clk_i) disable iff (por_s)
    src_act |=> core_rst_o);
  a_r7_strobe_single: assert property (@(posedge clk_i) disable iff (por_s)
    wake_stb_o |=> !wake_stb_o);
  a_r7_strobe_at_release: assert property (@(posedge clk_i) disable iff (por_s)
    wake_stb_o |-> (!core_rst_o && $past(core_rst_o)));
  a_r11_carrier_quiet: assert property (@(posedge clk_i) disable iff (por_s)
    core_rst_o |-> !carrier_o);
endmodule

// File: tb/rst_seq_ctrl_tb.sv
module rst_seq_ctrl_tb;
  localparam int unsigned S    = 16;
  localparam int unsigned SYNC = 2;
  localparam int unsigned PCW  = 12;

  // Vector: {kind[1:0], halt}; kind 0 = pin, 1 = watchdog, 2 = power-on
  localparam logic [2:0] VEC [8] = '{
    3'b01_0, 3'b00_0, 3'b00_1, 3'b01_1,
    3'b00_0, 3'b10_1, 3'b01_1, 3'b10_0
  };

  logic clk = 1'b0;
  logic por_i = 1'b1, pin_rst_ni = 1'b1, wdt_tmo_i = 1'b0, halt_i = 1'b0;
  logic carrier_req_i = 1'b1;
  logic core_rst_o, wake_stb_o, to_flag_o, pdf_flag_o;
  logic [PCW-1:0] pc_vec_o;
  logic io_input_o, sp_init_o, carrier_o;

  int n_tests = 0, n_fail = 0;
  bit finished = 1'b0;
  bit m_to = 1'b0, m_pdf = 1'b0;

  always #2 clk = ~clk;

  rst_seq_ctrl #(.STARTUP_CYC(S), .SYNC_STG(SYNC), .PC_W(PCW)) u_dut (
    .clk_i(clk), .por_i(por_i), .pin_rst_ni(pin_rst_ni), .wdt_tmo_i(wdt_tmo_i),
    .halt_i(halt_i), .carrier_req_i(carrier_req_i), .core_rst_o(core_rst_o),
    .wake_stb_o(wake_stb_o), .to_flag_o(to_flag_o), .pdf_flag_o(pdf_flag_o),
    .pc_vec_o(pc_vec_o), .io_input_o(io_input_o), .sp_init_o(sp_init_o),
    .carrier_o(carrier_o));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_rel(output int n);
    n = 0;
    do begin
      @(posedge clk); n++;
      @(negedge clk);
    end while (core_rst_o && n < 1000);
  endtask

  task automatic chk_held(input string req);
    chk(core_rst_o && io_input_o && sp_init_o && !carrier_o && pc_vec_o == '0,
        req, {core_rst_o, io_input_o, sp_init_o, carrier_o}, 4'b1110);
  endtask

  task automatic chk_after(input string req, input int n, input int exp_n);
    chk(n == exp_n, {req, " release edge"}, n, exp_n);
    chk(wake_stb_o == 1'b1, "R7 strobe at release", wake_stb_o, 1);
    chk(to_flag_o == m_to, {req, " TO"}, to_flag_o, m_to);
    chk(pdf_flag_o == m_pdf, {req, " PDF"}, pdf_flag_o, m_pdf);
    @(negedge clk);
    chk(wake_stb_o == 1'b0, "R7 strobe one cycle", wake_stb_o, 0);
  endtask

  task automatic run_cause(input logic [1:0] kind, input logic hlt);
    int n, e;
    string tag;
    @(negedge clk);
    halt_i = hlt;
    case (kind)
      2'd0: begin
        tag = hlt ? "R4" : "R3";
        pin_rst_ni = 1'b0;
        repeat (3) @(negedge clk);
        chk_held({tag, " R11 held"});
        pin_rst_ni = 1'b1;
        wait_rel(n);
        e = hlt ? SYNC + S : SYNC + 1;
        if (hlt) begin m_to = 1'b0; m_pdf = 1'b1; end
      end
      2'd1: begin
        tag = hlt ? "R6" : "R5";
        wdt_tmo_i = 1'b1;
        @(negedge clk);
        wdt_tmo_i = 1'b0;
        chk(core_rst_o == 1'b1, {tag, " reset asserted"}, core_rst_o, 1);
        wait_rel(n);
        e = hlt ? S : 1;
        m_to = 1'b1;
        if (hlt) m_pdf = 1'b1;
      end
      default: begin
        tag = "R2";
        por_i = 1'b1;
        repeat (3) @(negedge clk);
        chk_held("R2 R11 held");
        por_i = 1'b0;
        wait_rel(n);
        e = SYNC + S;
        m_to = 1'b0; m_pdf = 1'b0;
      end
    endcase
    halt_i = 1'b0;
    chk_after(tag, n, e);
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    // Reset state under power-on (R1, R11)
    chk_held("R1 R11 reset state");
    chk(pc_vec_o == '0, "R11 vector", int'(pc_vec_o), 0);
    por_i = 1'b0;
    wait_rel(n);
    chk_after("R2", n, SYNC + S);

    for (int i = 0; i < 8; i++) run_cause(VEC[i][2:1], VEC[i][0]);

    // R8: power-on and pin together in HALT -> power-on wins, flags 00
    @(negedge clk);
    halt_i = 1'b1; por_i = 1'b1; pin_rst_ni = 1'b0;
    repeat (3) @(negedge clk);
    por_i = 1'b0; pin_rst_ni = 1'b1;
    wait_rel(n);
    halt_i = 1'b0;
    m_to = 1'b0; m_pdf = 1'b0;
    chk_after("R8 por over pin", n, SYNC + S);

    // R8: pin and watchdog in same cycle -> pin wins, TO stays 0
    @(negedge clk);
    pin_rst_ni = 1'b0; wdt_tmo_i = 1'b1;
    @(negedge clk);
    pin_rst_ni = 1'b1; wdt_tmo_i = 1'b0;
    wait_rel(n);
    chk_after("R8 pin over wdt", n, SYNC + 1);

    // R9 / R10: pin wake from HALT, watchdog during count, then restart by pin
    @(negedge clk);
    halt_i = 1'b1; pin_rst_ni = 1'b0;
    @(negedge clk);
    pin_rst_ni = 1'b1; halt_i = 1'b0;
    m_to = 1'b0; m_pdf = 1'b1;
    repeat (6) @(negedge clk);
    wdt_tmo_i = 1'b1;
    @(negedge clk);
    wdt_tmo_i = 1'b0;
    chk(to_flag_o == 1'b0, "R10 wdt ignored in reset", to_flag_o, 0);
    repeat (2) @(negedge clk);
    chk(core_rst_o == 1'b1, "R9 still counting", core_rst_o, 1);
    pin_rst_ni = 1'b0;
    @(negedge clk);
    pin_rst_ni = 1'b1;
    wait_rel(n);
    chk_after("R9 restart", n, SYNC + S);

    // R10: HALT raised while pin reset held -> ignored, no delay, flags kept
    @(negedge clk);
    pin_rst_ni = 1'b0;
    repeat (2) @(negedge clk);
    halt_i = 1'b1;
    repeat (2) @(negedge clk);
    pin_rst_ni = 1'b1; halt_i = 1'b0;
    wait_rel(n);
    chk_after("R10 halt ignored", n, SYNC + 1);

    // R11: carrier follows request one cycle later once running
    chk(carrier_o == 1'b1, "R11 carrier on", carrier_o, 1);
    carrier_req_i = 1'b0;
    @(negedge clk);
    chk(carrier_o == 1'b0, "R11 carrier off", carrier_o, 0);
    chk(io_input_o == 1'b0 && sp_init_o == 1'b0, "R11 init released",
        {io_input_o, sp_init_o}, 0);
    // R12: default-width counter bound is checked by the design's own property
    chk(core_rst_o == 1'b0, "R12 idle after count", core_rst_o, 0);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule